// File: doc/BRIEF.md
# Serial Receiver with Error Status

This block is the receive half of an asynchronous serial port. It watches a single serial line, recovers characters framed as one start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit, and places each recovered byte in a small receive queue. Bit timing comes from an external tick pulsing at sixteen times the bit rate. Each bit is sampled near its centre.

Every queued entry carries the byte and two per-character error bits: framing and parity. Three sticky status flags record overrun, framing and parity events. A masked OR of these flags drives one interrupt line. Software drains the queue through a valid/ready stream port. It clears flags by pulsing a strobe together with a write-one-to-clear bit mask. On the stream port, `rd_valid` stays high and the head entry stays stable for as long as the queue is non-empty and `rd_ready` is low. An entry leaves the queue on any clock edge where both are high.

The queue cannot push back on the serial line. When a character completes while the queue is full and nothing is being popped, the oldest entry is dropped to make room for it, and the event is reported as an overrun.

Top module: `srx_checked`

## Requirements
- R1: A well-formed frame produces one queue entry whose `rd_data` equals the eight data bits, taken first bit on the line as bit 0. The entry's `rd_ferr` and `rd_perr` are 0.
- R2: A low pulse on the line shorter than half a bit time is ignored: no entry is queued, and a later valid frame is received normally.
- R3: With `par_en` = 0 no parity bit is expected, the stop bit follows data bit 7, and status flag bit 2 (parity) is never set.
- R4: With `par_en` = 1 a parity bit follows data bit 7. The expected parity bit is the XOR of the data bits, inverted when `par_odd` = 1. A mismatch sets `rd_perr` on that entry and sets flag bit 2.
- R5: If the line is low at the middle of the stop bit, the entry is still queued with `rd_ferr` = 1 and flag bit 1 (framing) is set. The receiver does not look for a new start bit until the line has returned high.
- R6: The queue holds 8 entries and delivers them in arrival order. While `rd_valid` = 1 and `rd_ready` = 0, the head entry holds steady unless an overrun replaces it.
- R7: A character that completes while the queue is full and no pop happens in that cycle discards the oldest entry and is stored as the newest. Flag bit 0 (overrun) is set.
- R8: Flags are sticky. A cycle with `clr_stb` = 1 clears exactly the flags whose `clr_bits` bit is 1. A new event in the same cycle keeps its flag set.
- R9: `irq` is 1 exactly when some flag bit is 1 and its matching `irq_en` bit is 1.
- R10: After reset `rd_valid`, `err_flags` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line, idle high, asynchronous |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| par_en | input | 1 | 1 = frames carry a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_valid | output | 1 | Queue head is valid |
| rd_ready | input | 1 | Consumer accepts the head entry |
| rd_data | output | 8 | Head entry data byte |
| rd_ferr | output | 1 | Head entry framing error |
| rd_perr | output | 1 | Head entry parity error |
| clr_stb | input | 1 | Flag clear strobe |
| clr_bits | input | 3 | Flags to clear: bit0 overrun, bit1 framing, bit2 parity |
| irq_en | input | 3 | Interrupt enable per flag, same bit order |
| err_flags | output | 3 | Sticky flags: bit0 overrun, bit1 framing, bit2 parity |
| irq | output | 1 | Error interrupt |

## Verification
A bit counter or tick phase that is off by one shifts every received byte by one position, or picks up the stop or parity bit as data. The sweep over all 256 byte values shows this in the first popped entry. A wrong parity sense or an inactive parity stage shows up as a spurious or missing `rd_perr` within one frame. Queue pointer or eviction faults show as out-of-order or missing bytes when the queue is drained after an overrun. Flag logic faults show at `err_flags` and `irq` one cycle after the event or clear strobe.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int DATA_W = 8;
  localparam int NFLAG  = 3;
  localparam int FL_OVR = 0;
  localparam int FL_FRM = 1;
  localparam int FL_PAR = 2;

  typedef struct packed {
    logic              perr;
    logic              ferr;
    logic [DATA_W-1:0] data;
  } srx_entry_t;
endpackage

// File: rtl/srx_deser.sv
module srx_deser #(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_in,
  input  logic          os_tick,
  input  logic          par_en,
  input  logic          par_odd,
  output logic          frm_vld,
  output logic [DW-1:0] frm_data,
  output logic          frm_ferr,
  output logic          frm_perr
);
  localparam int CW  = $clog2(OSR);
  localparam int BW  = $clog2(DW + 1);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [BW-1:0] TOPB = BW'(DW - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_WAITHI} rx_st_t;

  rx_st_t        st;
  logic [1:0]    sync_q;
  logic          line;
  logic [CW-1:0] tcnt;
  logic [BW-1:0] bcnt;
  logic [DW-1:0] shreg;
  logic          par_bit;
  logic          par_used;
  logic          at_end;

  assign line   = sync_q[1];
  assign at_end = os_tick && (tcnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], line_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      tcnt     <= '0;
      bcnt     <= '0;
      shreg    <= '0;
      par_bit  <= 1'b0;
      par_used <= 1'b0;
      frm_vld  <= 1'b0;
      frm_data <= '0;
      frm_ferr <= 1'b0;
      frm_perr <= 1'b0;
    end else begin
      frm_vld <= 1'b0;
      if (os_tick && st != S_IDLE && st != S_WAITHI && !at_end && !(st == S_START && tcnt == MID))
        tcnt <= tcnt + 1'b1;
      case (st)
        S_IDLE: begin
          if (!line) begin
            st   <= S_START;
            tcnt <= '0;
          end
        end
        S_START: begin
          if (os_tick && tcnt == MID) begin
            if (!line) begin
              st   <= S_DATA;
              tcnt <= '0;
              bcnt <= '0;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        S_DATA: begin
          if (at_end) begin
            tcnt  <= '0;
            shreg <= {line, shreg[DW-1:1]};
            if (bcnt == TOPB) begin
              par_used <= par_en;
              st       <= par_en ? S_PAR : S_STOP;
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end
        end
        S_PAR: begin
          if (at_end) begin
            tcnt    <= '0;
            par_bit <= line;
            st      <= S_STOP;
          end
        end
        S_STOP: begin
          if (at_end) begin
            tcnt     <= '0;
            frm_vld  <= 1'b1;
            frm_data <= shreg;
            frm_ferr <= !line;
            frm_perr <= par_used && (par_bit != ((^shreg) ^ par_odd));
            st       <= line ? S_IDLE : S_WAITHI;
          end
        end
        S_WAITHI: begin
          if (line) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frm_vld |=> !frm_vld); // R1
  AST_FERR_WAITS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld && frm_ferr) |-> (st == S_WAITHI)); // R5
  AST_NO_START_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAITHI && !line) |=> (st == S_WAITHI)); // R5
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
  import srx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  srx_entry_t push_ent,
  output logic       out_valid,
  input  logic       out_ready,
  output srx_entry_t out_ent,
  output logic       ovr_evt
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0]   LASTP = AW'(DEPTH - 1);
  localparam logic [CNTW-1:0] FULLC = CNTW'(DEPTH);

  srx_entry_t      mem [DEPTH];
  logic [AW-1:0]   wp, rp;
  logic [CNTW-1:0] cnt;
  logic            full, pop, evict, grow;

  assign full      = (cnt == FULLC);
  assign out_valid = (cnt != '0);
  assign pop       = out_valid && out_ready;
  assign evict     = push && full && !pop;
  assign grow      = push && !full;
  assign out_ent   = mem[rp];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == LASTP) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_ent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      ovr_evt <= 1'b0;
    end else begin
      ovr_evt <= evict;
      if (push)         wp <= nxt(wp);
      if (pop || evict) rp <= nxt(rp);
      if (grow && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULLC); // R6
  AST_HOLD_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !push) |=> (out_valid && $stable(out_ent))); // R6
  AST_OVR_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !out_ready) |=> (ovr_evt && full)); // R7
endmodule

// File: rtl/srx_status.sv
module srx_status #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_ev,
  input  logic          clr_stb,
  input  logic [NF-1:0] clr_bits,
  input  logic [NF-1:0] irq_en,
  output logic [NF-1:0] flags,
  output logic          irq
);
  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      flags[i] <= 1'b0;
      else if (set_ev[i])              flags[i] <= 1'b1;
      else if (clr_stb && clr_bits[i]) flags[i] <= 1'b0;
    end

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !(clr_stb && clr_bits[i])) |=> flags[i]); // R8
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev[i] |=> flags[i]); // R8
  end

  assign irq = |(flags & irq_en);
endmodule

// File: rtl/srx_checked.sv
module srx_checked
  import srx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic              os_tick,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_ferr,
  output logic              rd_perr,
  input  logic              clr_stb,
  input  logic [NFLAG-1:0]  clr_bits,
  input  logic [NFLAG-1:0]  irq_en,
  output logic [NFLAG-1:0]  err_flags,
  output logic              irq
);
  logic              frm_vld, frm_ferr, frm_perr, ovr_evt;
  logic [DATA_W-1:0] frm_data;
  srx_entry_t        in_ent, head;
  logic [NFLAG-1:0]  set_ev;

  srx_deser #(.OSR(OSR), .DW(DATA_W)) u_deser (
    .clk(clk), .rst_n(rst_n), .line_in(rxd), .os_tick(os_tick),
    .par_en(par_en), .par_odd(par_odd),
    .frm_vld(frm_vld), .frm_data(frm_data), .frm_ferr(frm_ferr), .frm_perr(frm_perr)
  );

  assign in_ent = '{perr: frm_perr, ferr: frm_ferr, data: frm_data};

  srx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(frm_vld), .push_ent(in_ent),
    .out_valid(rd_valid), .out_ready(rd_ready), .out_ent(head), .ovr_evt(ovr_evt)
  );

  assign rd_data = head.data;
  assign rd_ferr = head.ferr;
  assign rd_perr = head.perr;

  always_comb begin
    set_ev         = '0;
    set_ev[FL_OVR] = ovr_evt;
    set_ev[FL_FRM] = frm_vld && frm_ferr;
    set_ev[FL_PAR] = frm_vld && frm_perr;
  end

  srx_status #(.NF(NFLAG)) u_status (
    .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .clr_stb(clr_stb),
    .clr_bits(clr_bits), .irq_en(irq_en), .flags(err_flags), .irq(irq)
  );
endmodule

// File: tb/tb_srx_checked.sv
module tb_srx_checked;
  localparam int BITCLK = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       os_tick;
  logic       par_en = 1'b0, par_odd = 1'b0;
  logic       rd_valid, rd_ready = 1'b0;
  logic [7:0] rd_data;
  logic       rd_ferr, rd_perr;
  logic       clr_stb = 1'b0;
  logic [2:0] clr_bits = 3'b000;
  logic [2:0] irq_en = 3'b000;
  logic [2:0] err_flags;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) os_tick <= 1'b0;
    else        os_tick <= ~os_tick;
  end

  srx_checked dut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .os_tick(os_tick),
    .par_en(par_en), .par_odd(par_odd),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_ferr(rd_ferr), .rd_perr(rd_perr),
    .clr_stb(clr_stb), .clr_bits(clr_bits), .irq_en(irq_en),
    .err_flags(err_flags), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic line_bit(input logic v);
    @(negedge clk);
    rxd = v;
    repeat (BITCLK - 1) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input bit with_par, input logic pbit,
                      input logic stopv);
    line_bit(1'b0);
    for (int i = 0; i < 8; i++) line_bit(b[i]);
    if (with_par) line_bit(pbit);
    line_bit(stopv);
    if (!stopv) begin
      line_bit(1'b0);
      line_bit(1'b0);
    end
    line_bit(1'b1);
  endtask

  task automatic pop_chk(input string req, input logic [7:0] d, input logic fe,
                         input logic pe);
    @(negedge clk);
    chk({req, " valid"}, int'(rd_valid), 1);
    chk({req, " data"}, int'(rd_data), int'(d));
    chk({req, " ferr"}, int'(rd_ferr), int'(fe));
    chk({req, " perr"}, int'(rd_perr), int'(pe));
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic clear(input logic [2:0] m);
    @(negedge clk);
    clr_bits = m;
    clr_stb  = 1'b1;
    @(negedge clk);
    clr_stb  = 1'b0;
    clr_bits = 3'b000;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] hold_a;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10 rd_valid", int'(rd_valid), 0);
    chk("R10 flags", int'(err_flags), 0);
    chk("R10 irq", int'(irq), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 rd_valid after release", int'(rd_valid), 0);

    // R1 R3 R4: sweep all bytes across parity modes with correct parity
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      b = 8'(v);
      par_en  = b[1] ^ b[4];
      par_odd = b[2];
      send(b, par_en, (^b) ^ par_odd, 1'b1);
      pop_chk("R1 sweep", b, 1'b0, 1'b0);
    end
    chk("R3 R4 no parity flag after correct sweep", int'(err_flags), 0);
    chk("R1 queue empty after sweep", int'(rd_valid), 0);

    // R4 parity mismatch, even sense
    irq_en  = 3'b111;
    par_en  = 1'b1;
    par_odd = 1'b0;
    send(8'hA5, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    chk("R4 parity flag", int'(err_flags), 3'b100);
    chk("R9 irq on parity", int'(irq), 1);
    // R6 head holds while not ready
    hold_a = rd_data;
    repeat (5) @(negedge clk);
    chk("R6 head stable", int'(rd_data), int'(hold_a));
    pop_chk("R4 entry perr", 8'hA5, 1'b0, 1'b1);
    // R4 odd sense mismatch
    par_odd = 1'b1;
    send(8'h03, 1'b1, 1'b0, 1'b1);
    pop_chk("R4 odd mismatch", 8'h03, 1'b0, 1'b1);
    // R9 masked
    irq_en = 3'b011;
    @(negedge clk);
    chk("R9 masked irq", int'(irq), 0);
    irq_en = 3'b111;
    // R8 partial clear keeps parity flag
    clear(3'b011);
    chk("R8 other clear keeps flag", int'(err_flags), 3'b100);
    clear(3'b100);
    chk("R8 W1C clears", int'(err_flags), 0);
    chk("R9 irq drops", int'(irq), 0);

    // R3: parity disabled, a would-be wrong parity not sent, flag stays clear
    par_en = 1'b0;
    send(8'h7E, 1'b0, 1'b0, 1'b1);
    pop_chk("R3 no parity frame", 8'h7E, 1'b0, 1'b0);
    chk("R3 flag clear", int'(err_flags), 0);

    // R5 framing error then recovery
    send(8'h3C, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R5 framing flag", int'(err_flags), 3'b010);
    pop_chk("R5 entry ferr", 8'h3C, 1'b1, 1'b0);
    send(8'h5A, 1'b0, 1'b0, 1'b1);
    pop_chk("R5 next frame ok", 8'h5A, 1'b0, 1'b0);
    clear(3'b111);

    // R2 false start
    @(negedge clk);
    rxd = 1'b0;
    repeat (8) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BITCLK) @(negedge clk);
    chk("R2 glitch ignored", int'(rd_valid), 0);
    send(8'hC3, 1'b0, 1'b0, 1'b1);
    pop_chk("R2 frame after glitch", 8'hC3, 1'b0, 1'b0);

    // R6 R7 fill and overrun
    for (int i = 0; i < 8; i++) send(8'h10 + 8'(i), 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    chk("R6 full no overrun", int'(err_flags), 0);
    send(8'h18, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    chk("R7 overrun flag", int'(err_flags), 3'b001);
    chk("R9 irq on overrun", int'(irq), 1);
    for (int i = 1; i <= 8; i++) pop_chk("R7 R6 order after evict", 8'h10 + 8'(i), 1'b0, 1'b0);
    chk("R6 drained", int'(rd_valid), 0);
    clear(3'b001);
    chk("R8 overrun cleared", int'(err_flags), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule